// File: doc/BRIEF.md
# Single-Channel DMA Engine with Auto-Reload

This block is one DMA channel. For each request it moves a single data item, either 8 or 16 bits wide. It first reads the item from a source address and then writes it to a destination address, using a simple request/grant memory bus. A request comes either from a hardware request pulse or from a software trigger bit in the control register. After each item the channel releases the bus.

The source address, destination address and item count each have two copies. Software writes the master copy. The working copy advances as items complete. When the count runs out, the terminal-count event reloads every working copy from its master. The channel then either stops until software acknowledges completion by reading the control register, or, with auto-repeat set, carries on under the reloaded settings. Each completion raises a one-cycle interrupt pulse.

The configuration port is a flat register port: a write strobe, a read strobe and a 2-bit select. Select 0 is the source address, 1 is the destination address, 2 is the count and 3 is control. A write to 0, 1 or 2 loads both the master and the working copy. A read of 0, 1 or 2 returns the working copy.

Top module: `dma_chan`

## Requirements
- R1: An item is started only while the enable bit (control bit 0) is 1 and the terminal-count flag (control bit 2) is 0. A request that arrives while either condition is false stays pending and is serviced once both conditions hold.
- R2: The count register holds the number of items minus one. After count+1 items with auto-repeat off, the terminal-count flag reads 1, and later requests are held until that flag is cleared.
- R3: A read of the control register returns the terminal-count flag and clears it. If that read falls in the same cycle that sets the flag, the read returns 0 and the flag stays set.
- R4: The working source and destination addresses advance after each item. On terminal count every working copy is reloaded from its master, so a read of the source register returns the programmed base again.
- R5: With auto-repeat (control bit 3) set, terminal count reloads the working copies, leaves the flag at 0 and still pulses the interrupt, and requests continue to be served with no register rewrite.
- R6: Writing 1 to control bit 1 launches one item, as a hardware request would. The bit always reads back as 0.
- R7: Each item takes one bus request: a read cycle at the source, then a write cycle at the destination. The bus request drops after the write completes. Clearing the enable bit holds the channel between items without losing a pending request.
- R8: For 16-bit items (control bit 4 set), bit 0 of both bus addresses is driven 0, so an odd address accesses the even address below it.
- R9: An address steps by 1 for 8-bit items and by 2 for 16-bit items. It stays fixed when its fixed-mode bit is set (control bit 5 for the source, bit 6 for the destination).
- R10: The interrupt is a one-cycle pulse in the cycle after the final item's write completes. This is the same cycle in which terminal count takes effect.
- R11: The write data equals the data read from the source. For 8-bit items the upper byte of the write data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe (a control read clears terminal count) |
| cfg_addr_i | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata_i | input | DW | Register write data |
| cfg_rdata_o | output | DW | Register read data (combinational) |
| dreq_i | input | 1 | Hardware transfer request pulse |
| bus_req_o | output | 1 | Bus ownership request, held for one item |
| bus_gnt_i | input | 1 | Bus grant |
| bus_valid_o | output | 1 | Bus access cycle active |
| bus_we_o | output | 1 | 1 = write to destination, 0 = read from source |
| bus_size16_o | output | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr_o | output | AW | Bus address (bit 0 forced low for 16-bit items) |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_rdy_i | input | 1 | Bus access complete |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
Two events can fall in the same cycle: software acknowledges completion by reading the control register, and the final item's write completes, which sets the flag. The bench provokes the collision by watching the bus at the falling edge. In the cycle where the last write is being accepted, it raises the control read strobe, so the read and the flag set share one rising edge. The result is judged by two values: the returned data must show the flag clear, and a second read must show the flag set and clear it. That second read proves the completion was not lost to the collision.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR} dma_st_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_TRIG = 1;
  localparam int CB_TC   = 2;
  localparam int CB_RPT  = 3;
  localparam int CB_SZ16 = 4;
  localparam int CB_FIX0 = 5; // +0 source, +1 destination
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic                 cfg_re_i,
  input  logic [1:0]           cfg_addr_i,
  input  logic [DW-1:0]        cfg_wdata_i,
  output logic [DW-1:0]        cfg_rdata_o,
  input  logic                 item_done_i,
  output logic [1:0][AW-1:0]   addr_o,
  output logic                 en_o,
  output logic                 tc_o,
  output logic                 size16_o,
  output logic                 trig_o,
  output logic                 irq_o
);
  localparam int NPTR = 2;

  logic [CW-1:0]   cnt_m, cnt_w;
  logic [NPTR-1:0] fix_q;
  logic            rpt_q;
  logic            last, set_tc, wr_ctrl, rd_ctrl;

  assign last    = (cnt_w == '0);
  assign set_tc  = item_done_i & last & ~rpt_q;
  assign wr_ctrl = cfg_we_i & (cfg_addr_i == SEL_CTRL);
  assign rd_ctrl = cfg_re_i & (cfg_addr_i == SEL_CTRL);
  assign trig_o  = wr_ctrl & cfg_wdata_i[CB_TRIG];

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    localparam logic [1:0] SEL = 2'(i);
    logic [AW-1:0] m_q, w_q, step;
    assign step = fix_q[i] ? '0 : (size16_o ? AW'(2) : AW'(1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q <= '0;
        w_q <= '0;
      end else if (cfg_we_i && cfg_addr_i == SEL) begin
        m_q <= cfg_wdata_i[AW-1:0];
        w_q <= cfg_wdata_i[AW-1:0];
      end else if (item_done_i) begin
        w_q <= last ? m_q : w_q + step;
      end
    end
    assign addr_o[i] = w_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_m <= '0;
      cnt_w <= '0;
    end else if (cfg_we_i && cfg_addr_i == SEL_CNT) begin
      cnt_m <= cfg_wdata_i[CW-1:0];
      cnt_w <= cfg_wdata_i[CW-1:0];
    end else if (item_done_i) begin
      cnt_w <= last ? cnt_m : cnt_w - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      rpt_q    <= 1'b0;
      size16_o <= 1'b0;
      fix_q    <= '0;
    end else if (wr_ctrl) begin
      en_o     <= cfg_wdata_i[CB_EN];
      rpt_q    <= cfg_wdata_i[CB_RPT];
      size16_o <= cfg_wdata_i[CB_SZ16];
      fix_q    <= cfg_wdata_i[CB_FIX0 +: NPTR];
    end
  end

  // set beats read-clear so a colliding acknowledge cannot lose a completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= item_done_i & last;
      if (set_tc)       tc_o <= 1'b1;
      else if (rd_ctrl) tc_o <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    unique case (cfg_addr_i)
      SEL_SRC: cfg_rdata_o[AW-1:0] = addr_o[0];
      SEL_DST: cfg_rdata_o[AW-1:0] = addr_o[1];
      SEL_CNT: cfg_rdata_o[CW-1:0] = cnt_w;
      default: begin
        cfg_rdata_o[CB_EN]            = en_o;
        cfg_rdata_o[CB_TC]            = tc_o;
        cfg_rdata_o[CB_RPT]           = rpt_q;
        cfg_rdata_o[CB_SZ16]          = size16_o;
        cfg_rdata_o[CB_FIX0 +: NPTR]  = fix_q;
      end
    endcase
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tc_i,
  input  logic          trig_i,
  input  logic          dreq_i,
  input  logic          size16_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_rdy_i,
  output logic          item_done_o
);
  localparam logic [DW-1:0] BYTE_MASK = DW'(8'hFF);
  localparam logic [AW-1:0] EVEN_MASK = ~AW'(1);

  dma_st_e       st_q, st_d;
  logic          pend_q, launch;
  logic [DW-1:0] data_q;
  logic [AW-1:0] raw_addr;

  assign launch = (st_q == ST_IDLE) & pend_q & en_i & ~tc_i;

  always_comb begin
    st_d        = st_q;
    item_done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (launch)    st_d = ST_ARB;
      ST_ARB:  if (bus_gnt_i) st_d = ST_RD;
      ST_RD:   if (bus_rdy_i) st_d = ST_WR;
      default: if (bus_rdy_i) begin
        st_d        = ST_IDLE;
        item_done_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= (pend_q & ~launch) | dreq_i | trig_i;
      if (st_q == ST_RD && bus_rdy_i)
        data_q <= size16_i ? bus_rdata_i : (bus_rdata_i & BYTE_MASK);
    end
  end

  assign raw_addr    = (st_q == ST_WR) ? dst_i : src_i;
  assign bus_addr_o  = size16_i ? (raw_addr & EVEN_MASK) : raw_addr;
  assign bus_req_o   = (st_q != ST_IDLE);
  assign bus_valid_o = (st_q == ST_RD) | (st_q == ST_WR);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_wdata_o = data_q;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_re_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  input  logic          dreq_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic          bus_size16_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_rdy_i,
  output logic          irq_o
);
  logic [1:0][AW-1:0] ptr;
  logic ctrl_en, ctrl_tc, ctrl_size16, sw_trig, item_done;

  dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_re_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .item_done_i (item_done),
    .addr_o      (ptr),
    .en_o        (ctrl_en),
    .tc_o        (ctrl_tc),
    .size16_o    (ctrl_size16),
    .trig_o      (sw_trig),
    .irq_o
  );

  dma_chan_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni,
    .en_i        (ctrl_en),
    .tc_i        (ctrl_tc),
    .trig_i      (sw_trig),
    .dreq_i,
    .size16_i    (ctrl_size16),
    .src_i       (ptr[0]),
    .dst_i       (ptr[1]),
    .bus_req_o, .bus_gnt_i, .bus_valid_o, .bus_we_o, .bus_addr_o,
    .bus_wdata_o, .bus_rdata_i, .bus_rdy_i,
    .item_done_o (item_done)
  );

  assign bus_size16_o = ctrl_size16;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_valid_o,
  input logic          bus_we_o,
  input logic          bus_rdy_i,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          irq_o,
  input logic          ctrl_en,
  input logic          ctrl_tc,
  input logic          ctrl_size16
);
  assert_start_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(ctrl_en && !ctrl_tc));

  assert_valid_in_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> bus_req_o);

  assert_wdata_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_we_o && !bus_rdy_i) |=> (bus_valid_o && bus_we_o && $stable(bus_wdata_o)));

  assert_even_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && ctrl_size16) |-> !bus_addr_o[0]);

  assert_irq_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_tc_with_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_tc) |-> irq_o);
endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .bus_req_o, .bus_valid_o, .bus_we_o, .bus_rdy_i,
  .bus_addr_o, .bus_wdata_o, .irq_o, .ctrl_en, .ctrl_tc, .ctrl_size16
);

// File: tb/dma_chan_test.sv
module dma_chan_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [15:0] RD_XOR = 16'h5A3C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_re = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic          dreq = 1'b0;
  logic          bus_req, bus_gnt, bus_valid, bus_we, bus_size16, bus_rdy, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int n_tests = 0, n_fail = 0;
  int wr_cnt = 0, irq_cnt = 0;
  logic [AW-1:0] last_rd_addr, last_wr_addr;
  logic [DW-1:0] last_wr_data;

  always #2 clk = ~clk;

  dma_chan #(.AW(AW), .CW(16), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .dreq_i(dreq), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_valid_o(bus_valid),
    .bus_we_o(bus_we), .bus_size16_o(bus_size16), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_rdy_i(bus_rdy), .irq_o(irq)
  );

  // bus responder
  assign bus_rdata = bus_addr ^ RD_XOR;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0;
      bus_rdy <= 1'b0;
    end else begin
      bus_gnt <= bus_req;
      bus_rdy <= bus_valid & ~bus_rdy;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_valid && bus_rdy) begin
        if (bus_we) begin
          last_wr_addr = bus_addr;
          last_wr_data = bus_wdata;
          wr_cnt++;
        end else last_rd_addr = bus_addr;
      end
      if (irq) irq_cnt++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cfg_re = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk); cfg_re = 1'b0;
  endtask

  task automatic hw_req();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic wait_wr(input int target);
    int n = 0;
    while (wr_cnt < target && n < 300) begin @(negedge clk); n++; end
    chk(wr_cnt >= target, "R7 item completes", wr_cnt, target);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] base, input int k, input logic sz, input logic fx);
    logic [15:0] a;
    a = base + 16'(k * (fx ? 0 : (sz ? 2 : 1)));
    return sz ? (a & 16'hFFFE) : a;
  endfunction

  typedef struct packed {
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] cnt;
    logic        sz;
    logic        sfix;
    logic        dfix;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'h0100, 16'h0200, 16'd2, 1'b0, 1'b0, 1'b0},
    '{16'h0301, 16'h0405, 16'd1, 1'b1, 1'b0, 1'b0},
    '{16'h0500, 16'h0600, 16'd2, 1'b1, 1'b0, 1'b1},
    '{16'h0700, 16'h0800, 16'd0, 1'b0, 1'b1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd, ctrl, exp_d;
    int base_wr, base_irq;

    idle(3);
    rst_n = 1'b1;
    idle(2);
    // reset state
    chk(!bus_req && !irq, "R1 reset outputs idle", {bus_req, irq}, 0);
    cfg_read(2'd3, rd);
    chk(rd == 16'h0, "R3 reset control", rd, 0);

    // vector table
    foreach (VECS[v]) begin
      ctrl = 16'h0001 | (16'(VECS[v].sz) << 4) | (16'(VECS[v].sfix) << 5) | (16'(VECS[v].dfix) << 6);
      cfg_write(2'd0, VECS[v].src);
      cfg_write(2'd1, VECS[v].dst);
      cfg_write(2'd2, VECS[v].cnt);
      cfg_write(2'd3, ctrl);
      base_irq = irq_cnt;
      for (int k = 0; k <= int'(VECS[v].cnt); k++) begin
        base_wr = wr_cnt;
        if (k % 2 == 0) cfg_write(2'd3, ctrl | 16'h0002);
        else hw_req();
        wait_wr(base_wr + 1);
        rd = exp_addr(VECS[v].src, k, VECS[v].sz, VECS[v].sfix);
        chk(last_rd_addr == rd, "R9 R8 source address", last_rd_addr, rd);
        exp_d = exp_addr(VECS[v].dst, k, VECS[v].sz, VECS[v].dfix);
        chk(last_wr_addr == exp_d, "R9 R8 destination address", last_wr_addr, exp_d);
        exp_d = VECS[v].sz ? (rd ^ RD_XOR) : ((rd ^ RD_XOR) & 16'h00FF);
        chk(last_wr_data == exp_d, "R11 write data", last_wr_data, exp_d);
        idle(2);
        chk(!bus_req, "R7 bus released after item", bus_req, 0);
        if (k == 0 && VECS[v].cnt != 0) begin
          cfg_read(2'd0, rd);
          exp_d = VECS[v].src + (VECS[v].sfix ? 16'd0 : (VECS[v].sz ? 16'd2 : 16'd1));
          chk(rd == exp_d, "R4 working source advances", rd, exp_d);
        end
      end
      idle(3);
      chk(irq_cnt == base_irq + 1, "R10 one irq per run", irq_cnt, base_irq + 1);
      cfg_read(2'd0, rd);
      chk(rd == VECS[v].src, "R4 source reloaded", rd, VECS[v].src);
      cfg_read(2'd2, rd);
      chk(rd == VECS[v].cnt, "R4 count reloaded", rd, VECS[v].cnt);
      cfg_read(2'd3, rd);
      chk(rd[2] == 1'b1, "R2 tc set after count+1 items", rd[2], 1);
      cfg_read(2'd3, rd);
      chk(rd[2] == 1'b0, "R3 read clears tc", rd[2], 0);
      cfg_write(2'd3, 16'h0000);
    end

    // R6: trigger bit reads 0
    cfg_write(2'd3, 16'h0002);
    cfg_read(2'd3, rd);
    chk(rd[1] == 1'b0, "R6 trigger reads zero", rd[1], 0);
    idle(10);
    chk(wr_cnt == base_wr + 1 && !bus_req, "R1 no item while disabled", bus_req, 0);
    // pending trigger is served once enabled
    base_wr = wr_cnt;
    cfg_write(2'd0, 16'h0900);
    cfg_write(2'd1, 16'h0A00);
    cfg_write(2'd2, 16'd3);
    cfg_write(2'd3, 16'h0001);
    wait_wr(base_wr + 1);
    chk(last_rd_addr == 16'h0900, "R1 pending request served on enable", last_rd_addr, 16'h0900);

    // R7: pause between items
    base_wr = wr_cnt;
    cfg_write(2'd3, 16'h0000);
    hw_req();
    idle(20);
    chk(wr_cnt == base_wr, "R7 paused while enable clear", wr_cnt, base_wr);
    cfg_write(2'd3, 16'h0001);
    wait_wr(base_wr + 1);
    chk(last_rd_addr == 16'h0901, "R7 resume at next address", last_rd_addr, 16'h0901);
    cfg_write(2'd3, 16'h0000);

    // R2: tc gates later requests
    cfg_write(2'd0, 16'h0B00);
    cfg_write(2'd1, 16'h0C00);
    cfg_write(2'd2, 16'd0);
    cfg_write(2'd3, 16'h0003);
    base_wr = wr_cnt;
    wait_wr(base_wr + 1);
    hw_req();
    idle(20);
    chk(wr_cnt == base_wr + 1 && !bus_req, "R2 request held while tc set", wr_cnt, base_wr + 1);
    cfg_read(2'd3, rd);
    chk(rd[2] == 1'b1, "R2 tc flag visible", rd[2], 1);
    wait_wr(base_wr + 2);
    chk(last_rd_addr == 16'h0B00, "R2 held request served after clear", last_rd_addr, 16'h0B00);
    idle(3);
    cfg_read(2'd3, rd);

    // R3: read-clear in the same cycle as tc set
    base_wr = wr_cnt;
    cfg_write(2'd3, 16'h0003);
    begin
      int n = 0;
      while (!(bus_valid && bus_we && bus_rdy) && n < 100) begin @(negedge clk); n++; end
    end
    cfg_re = 1'b1; cfg_addr = 2'd3;
    #1 rd = cfg_rdata;
    @(negedge clk); cfg_re = 1'b0;
    chk(rd[2] == 1'b0, "R3 colliding read returns old flag", rd[2], 0);
    cfg_read(2'd3, rd);
    chk(rd[2] == 1'b1, "R3 set wins over colliding clear", rd[2], 1);
    cfg_read(2'd3, rd);
    chk(rd[2] == 1'b0, "R3 later read clears", rd[2], 0);
    cfg_write(2'd3, 16'h0000);

    // R5: auto-repeat
    cfg_write(2'd0, 16'h0D00);
    cfg_write(2'd1, 16'h0E00);
    cfg_write(2'd2, 16'd1);
    cfg_write(2'd3, 16'h0009);
    base_irq = irq_cnt;
    for (int k = 0; k < 4; k++) begin
      base_wr = wr_cnt;
      hw_req();
      wait_wr(base_wr + 1);
      exp_d = 16'h0D00 + 16'(k % 2);
      chk(last_rd_addr == exp_d, "R5 repeat reloads source", last_rd_addr, exp_d);
    end
    idle(3);
    chk(irq_cnt == base_irq + 2, "R5 irq each completion", irq_cnt, base_irq + 2);
    cfg_read(2'd3, rd);
    chk(rd[2] == 1'b0, "R5 tc stays clear on repeat", rd[2], 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule